// File: doc/BRIEF.md
# Interval-Constrained Event Timer

This block guards the time between a start event and the stop event that follows it. Each start carries a shortest and a longest allowed duration, counted in score ticks. Score ticks are one-cycle enable pulses, much slower than the system clock. A control machine runs on every system clock. It steers two countdown counters: one tracks the time left before the shortest duration is met, and the other tracks the time left before the longest duration runs out. Once the shortest duration has passed, a performer's trigger may end the interval early. If no trigger arrives, the interval ends by itself when the longest duration runs out. A trigger that arrives before the shortest duration has passed is ignored.

More start events may arrive while the shortest duration is still pending. Each one is merged into the running interval, so the result meets every constraint. The earliest end point moves later if the new constraint asks for it, and the latest end point moves earlier if the new constraint asks for it. A parent block can abort the interval at any time with a kill input. The block passes that kill on to its own children and records that it was killed. Stop and kill leave the block as single-cycle pulses. A level output shows that the block has reached its final state.

Top module: `interval_ctrl`

## Requirements
- R1: After synchronous reset the block waits for a start event. In this state stop_o, kill_o, done_o and killed_o are all 0, and ticks have no effect.
- R2: On a start_i pulse in the waiting state, min_dur_i and max_dur_i are sampled. One cycle later both counters are loaded from these values. Without a trigger, stop_o and kill_o pulse once the maximum counter has counted max_dur_i ticks.
- R3: If the minimum and maximum durations are equal, the interval ends by itself after exactly that many ticks. No trigger is needed.
- R4: A rising edge on trig_i that arrives while the minimum duration is still pending has no effect. The interval still ends at its normal forced end.
- R5: trig_i is an asynchronous level. It passes through two synchronizer flops and then a rising-edge detector. A rising edge that arrives after the minimum duration has elapsed ends the interval. stop_o and kill_o go high three system clocks after trig_i rises.
- R6: A start_i pulse while the minimum duration is pending merges the new durations into the running interval. The next cycle sets the minimum counter to the larger of its remaining count and the new minimum. It sets the maximum counter to the smaller of its remaining count and the new maximum.
- R7: A kill_i pulse in any state other than the final one moves the block to the final state in the next cycle. It raises kill_o for one cycle and sets killed_o. stop_o stays low.
- R8: stop_o and kill_o are pulses of a single system clock, and stop_o never rises without kill_o.
- R9: The final state is terminal. done_o stays 1, and further start, trigger, kill or tick inputs produce no pulse until reset.
- R10: The counters move only on tick_i cycles that occur while the minimum duration is pending or while the block waits for its end. Ticks in the load and merge cycles are not counted. Without ticks the interval never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle score-tick enable |
| start_i | input | 1 | Start event pulse; samples the durations |
| trig_i | input | 1 | Asynchronous performer trigger level |
| kill_i | input | 1 | Abort request from the parent |
| min_dur_i | input | 16 | Shortest allowed duration in ticks |
| max_dur_i | input | 16 | Longest allowed duration in ticks |
| stop_o | output | 1 | Pulse: interval ended by trigger or by the longest duration running out |
| kill_o | output | 1 | Pulse: abort request passed on to children |
| done_o | output | 1 | Level: block is in its final state |
| killed_o | output | 1 | Level: the final state was reached through a parent kill |

## Verification
The hardest case to reach from the ports is a merge in which one counter is kept and the other is replaced. It is reached only when a second start lands while the minimum is still pending, after the right number of ticks. The stimulus gets there by lining starts up with the tick phase and replaying both worked merge examples. It checks the tick count at the forced stop, so a wrong choice of larger or smaller shows up as a wrong end time. Random runs then place starts, trigger edges and kills at arbitrary cycles against a cycle-level model, including collisions of a start with a tick or of a kill with a load cycle.

// File: rtl/interval_pkg.sv
package interval_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_NEW      = 3'd1,
        ST_WAIT_MIN = 3'd2,
        ST_ADD      = 3'd3,
        ST_WAIT_END = 3'd4,
        ST_STOP     = 3'd5
    } phase_e;

    typedef struct packed {
        logic stop;
        logic kill;
        logic killed;
    } end_flags_t;

    function automatic logic phase_counts(input phase_e p);
        return (p == ST_WAIT_MIN) || (p == ST_WAIT_END);
    endfunction

    function automatic logic phase_loads(input phase_e p);
        return (p == ST_NEW) || (p == ST_ADD);
    endfunction

endpackage

// File: rtl/ivl_trig_sync.sv
module ivl_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[TOP];
        end
    end

    assign rise_o = chain_q[TOP] & ~last_q;
endmodule

// File: rtl/ivl_countdown.sv
module ivl_countdown #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    input  logic         tick_i,
    output logic [W-1:0] count_o,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/ivl_sequencer.sv
module ivl_sequencer
    import interval_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         trig_rise_i,
    input  logic         kill_i,
    input  logic [W-1:0] min_dur_i,
    input  logic [W-1:0] max_dur_i,
    input  logic [W-1:0] min_cnt_i,
    input  logic [W-1:0] max_cnt_i,
    input  logic         min_zero_i,
    input  logic         max_zero_i,
    output logic         load_o,
    output logic         run_o,
    output logic [W-1:0] min_load_o,
    output logic [W-1:0] max_load_o,
    output phase_e       phase_o,
    output logic         stop_o,
    output logic         kill_o,
    output logic         killed_o
);
    phase_e     st_q, st_d;
    logic [W-1:0] dmin_q, dmax_q;
    end_flags_t flags_d, flags_q;

    // next phase and end flags
    always_comb begin
        st_d    = st_q;
        flags_d = '0;
        if (kill_i && (st_q != ST_STOP)) begin
            st_d           = ST_STOP;
            flags_d.kill   = 1'b1;
            flags_d.killed = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) st_d = ST_NEW;
                end
                ST_NEW: st_d = ST_WAIT_MIN;
                ST_WAIT_MIN: begin
                    if (max_zero_i) begin
                        st_d         = ST_STOP;
                        flags_d.stop = 1'b1;
                        flags_d.kill = 1'b1;
                    end else if (start_i) begin
                        st_d = ST_ADD;
                    end else if (min_zero_i) begin
                        st_d = ST_WAIT_END;
                    end
                end
                ST_ADD: st_d = ST_WAIT_MIN;
                ST_WAIT_END: begin
                    if (max_zero_i || trig_rise_i) begin
                        st_d         = ST_STOP;
                        flags_d.stop = 1'b1;
                        flags_d.kill = 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            flags_q <= '0;
            dmin_q  <= '0;
            dmax_q  <= '0;
        end else begin
            st_q           <= st_d;
            flags_q.stop   <= flags_d.stop;
            flags_q.kill   <= flags_d.kill;
            flags_q.killed <= flags_q.killed | flags_d.killed;
            if (start_i && ((st_q == ST_IDLE) || (st_q == ST_WAIT_MIN))) begin
                dmin_q <= min_dur_i;
                dmax_q <= max_dur_i;
            end
        end
    end

    // counter control: load on NEW, merge on ADD, count while waiting
    always_comb begin
        load_o     = phase_loads(st_q);
        run_o      = phase_counts(st_q);
        min_load_o = dmin_q;
        max_load_o = dmax_q;
        if (st_q == ST_ADD) begin
            min_load_o = (min_cnt_i > dmin_q) ? min_cnt_i : dmin_q;
            max_load_o = (max_cnt_i < dmax_q) ? max_cnt_i : dmax_q;
        end
    end

    assign phase_o  = st_q;
    assign stop_o   = flags_q.stop;
    assign kill_o   = flags_q.kill;
    assign killed_o = flags_q.killed;
endmodule

// File: rtl/interval_ctrl.sv
module interval_ctrl
    import interval_pkg::*;
#(
    parameter int DUR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             trig_i,
    input  logic             kill_i,
    input  logic [DUR_W-1:0] min_dur_i,
    input  logic [DUR_W-1:0] max_dur_i,
    output logic             stop_o,
    output logic             kill_o,
    output logic             done_o,
    output logic             killed_o
);
    logic             trig_rise;
    logic             load_w, run_w;
    logic [DUR_W-1:0] min_load, max_load;
    logic [DUR_W-1:0] min_cnt, max_cnt;
    logic             min_zero, max_zero;
    phase_e           phase_w;

    ivl_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (trig_i),
        .rise_o  (trig_rise)
    );

    ivl_countdown #(.W(DUR_W)) i_min_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_w),
        .load_val_i (min_load),
        .run_i      (run_w),
        .tick_i     (tick_i),
        .count_o    (min_cnt),
        .zero_o     (min_zero)
    );

    ivl_countdown #(.W(DUR_W)) i_max_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_w),
        .load_val_i (max_load),
        .run_i      (run_w),
        .tick_i     (tick_i),
        .count_o    (max_cnt),
        .zero_o     (max_zero)
    );

    ivl_sequencer #(.W(DUR_W)) i_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .trig_rise_i (trig_rise),
        .kill_i      (kill_i),
        .min_dur_i   (min_dur_i),
        .max_dur_i   (max_dur_i),
        .min_cnt_i   (min_cnt),
        .max_cnt_i   (max_cnt),
        .min_zero_i  (min_zero),
        .max_zero_i  (max_zero),
        .load_o      (load_w),
        .run_o       (run_w),
        .min_load_o  (min_load),
        .max_load_o  (max_load),
        .phase_o     (phase_w),
        .stop_o      (stop_o),
        .kill_o      (kill_o),
        .killed_o    (killed_o)
    );

    assign done_o = (phase_w == ST_STOP);
endmodule

// File: rtl/interval_ctrl_checker.sv
module interval_ctrl_checker
    import interval_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             kill_i,
    input logic             stop_o,
    input logic             kill_o,
    input logic             done_o,
    input logic             killed_o,
    input phase_e           phase,
    input logic [DUR_W-1:0] min_cnt,
    input logic [DUR_W-1:0] max_cnt
);
    a_r7_kill_forces_end: assert property (@(posedge clk) disable iff (rst)
        (kill_i && phase != ST_STOP) |=> (done_o && killed_o && kill_o && !stop_o));

    a_r8_stop_has_kill: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> kill_o);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        kill_o |=> !kill_o);

    a_r9_terminal: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && $stable(min_cnt) && $stable(max_cnt)));

    a_r9_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(done_o)) |-> !kill_o);

    a_r6_merge_tightens: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ADD) |=> (min_cnt >= $past(min_cnt) && max_cnt <= $past(max_cnt)));

    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && (phase == ST_WAIT_MIN || phase == ST_WAIT_END))
            |=> ($stable(min_cnt) && $stable(max_cnt)));

    a_r4_no_early_stop: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_WAIT_MIN && max_cnt != '0 && !kill_i) |=> !stop_o);
endmodule

bind interval_ctrl interval_ctrl_checker #(.DUR_W(DUR_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .kill_i   (kill_i),
    .stop_o   (stop_o),
    .kill_o   (kill_o),
    .done_o   (done_o),
    .killed_o (killed_o),
    .phase    (phase_w),
    .min_cnt  (min_cnt),
    .max_cnt  (max_cnt)
);

// File: tb/test_interval_ctrl.sv
module test_interval_ctrl;
    localparam int TICK_DIV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        start_i = 1'b0;
    logic        trig_i = 1'b0;
    logic        kill_i = 1'b0;
    logic [15:0] min_dur_i = '0;
    logic [15:0] max_dur_i = '0;
    logic        stop_o, kill_o, done_o, killed_o;

    int errors = 0;
    int checks = 0;
    int tick_cnt = 0;
    int ticks_seen = 0;
    bit tick_en = 1'b1;
    string cur_req = "R1";

    always #10 clk = ~clk;

    interval_ctrl i_interval_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i),
        .trig_i(trig_i), .kill_i(kill_i), .min_dur_i(min_dur_i),
        .max_dur_i(max_dur_i), .stop_o(stop_o), .kill_o(kill_o),
        .done_o(done_o), .killed_o(killed_o)
    );

    // cycle-level reference model: 0 idle,1 load,2 min pending,3 merge,4 wait end,5 final
    int          m_st = 0;
    logic [15:0] m_mn = 0, m_mx = 0, m_dmin = 0, m_dmax = 0;
    logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic        m_stop = 0, m_kill = 0, m_killed = 0;

    function automatic logic [15:0] bigger(input logic [15:0] a, input logic [15:0] b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [15:0] smaller(input logic [15:0] a, input logic [15:0] b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_mn = 0; m_mx = 0; m_dmin = 0; m_dmax = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_stop = 0; m_kill = 0; m_killed = 0;
        end else begin
            int          nst;
            logic        trg, ns, nk;
            logic [15:0] nmn, nmx;
            trg = m_s2 & ~m_s3;
            nst = m_st; ns = 0; nk = 0;
            nmn = m_mn; nmx = m_mx;
            if (m_st == 1) begin nmn = m_dmin; nmx = m_dmax; end
            if (m_st == 3) begin nmn = bigger(m_mn, m_dmin); nmx = smaller(m_mx, m_dmax); end
            if ((m_st == 2 || m_st == 4) && tick_i) begin
                if (m_mn != 0) nmn = m_mn - 1;
                if (m_mx != 0) nmx = m_mx - 1;
            end
            if (kill_i && m_st != 5) begin
                nst = 5; nk = 1; m_killed = 1;
            end else begin
                case (m_st)
                    0: if (start_i) nst = 1;
                    1: nst = 2;
                    2: if (m_mx == 0) begin nst = 5; ns = 1; nk = 1; end
                       else if (start_i) nst = 3;
                       else if (m_mn == 0) nst = 4;
                    3: nst = 2;
                    4: if (m_mx == 0 || trg) begin nst = 5; ns = 1; nk = 1; end
                    default: nst = m_st;
                endcase
            end
            if (start_i && (m_st == 0 || m_st == 2)) begin m_dmin = min_dur_i; m_dmax = max_dur_i; end
            m_st = nst; m_mn = nmn; m_mx = nmx; m_stop = ns; m_kill = nk;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_i;
        end
    end

    task automatic cyc();
        @(negedge clk);
        checks++;
        if (stop_o !== m_stop || kill_o !== m_kill || done_o !== (m_st == 5) || killed_o !== m_killed) begin
            errors++;
            $display("FAIL %s model compare: actual stop=%b kill=%b done=%b killed=%b expected %b %b %b %b",
                     cur_req, stop_o, kill_o, done_o, killed_o, m_stop, m_kill, (m_st == 5), m_killed);
        end
        if (tick_i) ticks_seen++;
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        tick_i = tick_en && (tick_cnt == 0);
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start_i = 0; trig_i = 0; kill_i = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
    endtask

    task automatic align();
        while (tick_cnt != 1) cyc();
    endtask

    task automatic pulse_start(input int mn, input int mx);
        min_dur_i = 16'(mn); max_dur_i = 16'(mx);
        start_i = 1'b1; cyc(); start_i = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        while (!(ticks_seen >= n && tick_cnt == 1)) cyc();
    endtask

    // returns ticks counted when stop_o seen, or -1
    task automatic wait_stop(input int limit, output int tks, output int cycles);
        tks = -1; cycles = 0;
        for (int i = 0; i < limit; i++) begin
            cyc(); cycles++;
            if (stop_o) begin tks = ticks_seen; return; end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int tks, cy;
        void'($urandom(32'd20240611));

        // R1 reset state
        cur_req = "R1";
        do_reset();
        check("R1", {stop_o, kill_o, done_o, killed_o}, 0, "outputs after reset");
        repeat (20) cyc();
        check("R1", {stop_o, kill_o, done_o}, 0, "idle ignores ticks");

        // R2 plain interval, forced end
        cur_req = "R2";
        align(); ticks_seen = 0; pulse_start(3, 7);
        wait_stop(400, tks, cy);
        check("R2", tks, 7, "ticks until forced stop");
        check("R2", kill_o, 1, "kill_o with stop");

        // R3 rigid interval
        cur_req = "R3"; do_reset();
        align(); ticks_seen = 0; pulse_start(4, 4);
        wait_stop(400, tks, cy);
        check("R3", tks, 4, "rigid interval ticks");

        // R6 merge example 1
        cur_req = "R6"; do_reset();
        align(); ticks_seen = 0; pulse_start(5, 10);
        wait_ticks(2); align(); pulse_start(5, 10);
        wait_stop(400, tks, cy);
        check("R6", tks, 10, "merge example 1 forced stop tick");

        // R6 merge example 2
        do_reset();
        align(); ticks_seen = 0; pulse_start(7, 20);
        wait_ticks(6); align(); pulse_start(5, 10);
        wait_stop(600, tks, cy);
        check("R6", tks, 16, "merge example 2 forced stop tick");

        // R4 early trigger ignored
        cur_req = "R4"; do_reset();
        align(); ticks_seen = 0; pulse_start(8, 12);
        wait_ticks(3); trig_i = 1; repeat (3) cyc(); trig_i = 0;
        wait_stop(400, tks, cy);
        check("R4", tks, 12, "early trigger ignored");

        // R5 trigger after minimum
        cur_req = "R5"; do_reset();
        align(); ticks_seen = 0; pulse_start(3, 12);
        wait_ticks(6); trig_i = 1;
        wait_stop(10, tks, cy);
        trig_i = 0;
        check("R5", tks, 6, "trigger ends interval at tick");
        check("R5", cy, 3, "trigger latency in clocks");

        // R7 kill while waiting for end, R8 one-cycle pulse
        cur_req = "R7"; do_reset();
        align(); ticks_seen = 0; pulse_start(2, 30);
        wait_ticks(4); kill_i = 1; cyc(); kill_i = 0;
        check("R7", {kill_o, stop_o, done_o, killed_o}, 4'b1011, "kill in wait-end");
        cur_req = "R8"; cyc();
        check("R8", kill_o, 0, "kill_o lasts one cycle");

        // R7 kill in idle
        cur_req = "R7"; do_reset();
        kill_i = 1; cyc(); kill_i = 0;
        check("R7", {kill_o, stop_o, done_o, killed_o}, 4'b1011, "kill in idle");

        // R9 terminal state
        cur_req = "R9";
        begin
            int pulses = 0;
            for (int i = 0; i < 60; i++) begin
                start_i = (i % 7 == 0); trig_i = (i % 11 < 4); kill_i = (i % 13 == 0);
                cyc();
                if (stop_o || kill_o) pulses++;
            end
            start_i = 0; trig_i = 0; kill_i = 0;
            check("R9", pulses, 0, "pulses after final state");
            check("R9", done_o, 1, "done_o held");
        end

        // R10 no ticks, no end
        cur_req = "R10"; do_reset();
        tick_en = 0; tick_i = 0;
        pulse_start(1, 2);
        begin
            int pulses = 0;
            for (int i = 0; i < 100; i++) begin
                trig_i = (i > 50); cyc();
                if (stop_o) pulses++;
            end
            trig_i = 0;
            check("R10", pulses + int'(done_o), 0, "no stop without ticks");
        end
        tick_en = 1;

        // random mix checked by the model every cycle
        cur_req = "R2 R4 R5 R6 R7 R8";
        for (int c = 0; c < 120; c++) begin
            do_reset();
            for (int k = 0; k < 250; k++) begin
                start_i = ($urandom % 30 == 0);
                min_dur_i = 16'($urandom % 10);
                max_dur_i = 16'($urandom % 16);
                if ($urandom % 12 == 0) trig_i = ~trig_i;
                kill_i = ($urandom % 400 == 0);
                cyc();
            end
            start_i = 0; kill_i = 0; trig_i = 0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule